// File: doc/BRIEF.md
# Metering Tone Period Discriminator

This block decides whether a squared-up line signal carries a valid call-charge metering tone. It runs entirely from a 3.579545 MHz reference clock. A system-select input chooses between the 12 kHz tone (logic 1) and the 16 kHz tone (logic 0). The block counts reference cycles between successive rising edges of the one-bit tone input. Each measured period is graded good or bad against a fixed window of counts for the selected system. Frequencies within ±1.5 % of nominal land inside the window. Frequencies beyond ±4 % fall outside it.

Each grade comes out as a one-cycle verdict strobe with a good/bad qualifier, which downstream packet logic can accumulate. A timeout issues a bad verdict when edges stop arriving. An active-low follower output goes low after a run of consecutive good verdicts and returns high after a run of consecutive bad verdicts. Shorter runs are absorbed, so single glitches do not reach the output, and the output still settles well inside 4 ms. The tone input and the reset release both pass through two-flop synchronisers.

Top module: `tpd_tone_detector`

## Requirements
- R1: While reset is asserted, and right after it is released, follower_no is 1 (no tone). The verdict strobe is 0 while reset is held. verdict_good_o is never 1 without verdict_valid_o.
- R2: With sys_sel_i = 0 (16 kHz), a period of 218 to 230 reference cycles inclusive is graded good (verdict_good_o = 1). Periods of 217 or fewer, and of 231 up to the timeout, are graded bad.
- R3: With sys_sel_i = 1 (12 kHz), a period of 290 to 306 reference cycles inclusive is graded good. Periods of 289 or fewer, and of 307 up to the timeout, are graded bad.
- R4: Every rising edge of tone_i that follows an earlier edge with no timeout in between yields exactly one verdict, and the strobe lasts one cycle. The first rising edge after idle or reset yields no verdict.
- R5: When no rising edge arrives, a bad verdict is issued every 268 cycles (16 kHz) or every 358 cycles (12 kHz).
- R6: follower_no goes from 1 to 0 on the clock edge after the 8th consecutive good verdict. It goes from 0 to 1 on the clock edge after the 8th consecutive bad verdict.
- R7: A run of fewer than 8 verdicts that disagree with the follower state, ended by an agreeing verdict, leaves follower_no unchanged.
- R8: follower_no responds to a steady in-band tone within 14318 reference cycles (4 ms) of its first edge. It de-responds within 14318 cycles of the tone stopping.
- R9: A verdict strobe is seen in the third clock cycle after the input rises: it is low two cycle-centres after the rise and high at the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 3.579545 MHz reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sys_sel_i | input | 1 | 1 selects 12 kHz detection, 0 selects 16 kHz |
| tone_i | input | 1 | Digitised tone input, asynchronous |
| follower_no | output | 1 | Active-low tone follower: 0 while a valid tone is present |
| verdict_valid_o | output | 1 | One-cycle strobe, one per graded period or timeout |
| verdict_good_o | output | 1 | Grade of the current verdict, 1 = in band |

## Verification
The assertions assume that sys_sel_i only changes while the line is idle. A switch during a tone could leave a period graded against the other window. They also assume that tone_i rises no more often than every few cycles, so verdict strobes never merge. The bench changes the system select only after an idle stretch longer than two timeouts. It drives tone_i on falling clock edges with whole-cycle periods in the 214 to 307 range, so each measured count equals the driven period exactly.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

  typedef enum logic {
    SYS_16K = 1'b0,
    SYS_12K = 1'b1
  } tpd_sys_e;

  typedef struct packed {
    logic valid;
    logic good;
  } tpd_verdict_t;

  function automatic int unsigned tpd_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tpd_reset_sync.sv
module tpd_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/tpd_edge_sync.sv
module tpd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;
  logic              last_q;
  logic              last_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_comb stage_d[g] = async_i;
    end else begin : g_next
      always_comb stage_d[g] = stage_q[g-1];
    end
  end

  always_comb begin
    last_d = stage_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      last_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      last_q  <= last_d;
    end
  end

  assign rise_o = stage_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tpd_period_meter.sv
module tpd_period_meter
  import tpd_pkg::*;
#(
  parameter int unsigned ACC16_LO = 218,
  parameter int unsigned ACC16_HI = 230,
  parameter int unsigned TMO16    = 268,
  parameter int unsigned ACC12_LO = 290,
  parameter int unsigned ACC12_HI = 306,
  parameter int unsigned TMO12    = 358,
  localparam int unsigned TMO_MAX = tpd_max(TMO16, TMO12),
  localparam int unsigned CNT_W   = $clog2(TMO_MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  tpd_sys_e     sys_i,
  input  logic         rise_i,
  output tpd_verdict_t verdict_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  tpd_verdict_t     verdict_q, verdict_d;
  logic [CNT_W-1:0] lo_lim, hi_lim, tmo_lim;
  logic             in_band;
  logic             expired;

  always_comb begin
    if (sys_i == SYS_12K) begin
      lo_lim  = CNT_W'(ACC12_LO);
      hi_lim  = CNT_W'(ACC12_HI);
      tmo_lim = CNT_W'(TMO12);
    end else begin
      lo_lim  = CNT_W'(ACC16_LO);
      hi_lim  = CNT_W'(ACC16_HI);
      tmo_lim = CNT_W'(TMO16);
    end
  end

  assign in_band = (cnt_q >= lo_lim) && (cnt_q <= hi_lim);
  assign expired = (cnt_q >= tmo_lim);

  always_comb begin
    cnt_d     = cnt_q;
    armed_d   = armed_q;
    verdict_d = '0;
    if (rise_i) begin
      cnt_d   = CNT_W'(1);
      armed_d = 1'b1;
      if (armed_q) begin
        verdict_d.valid = 1'b1;
        verdict_d.good  = in_band;
      end
    end else if (expired) begin
      cnt_d           = CNT_W'(1);
      armed_d         = 1'b0;
      verdict_d.valid = 1'b1;
      verdict_d.good  = 1'b0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      armed_q   <= 1'b0;
      verdict_q <= '0;
    end else begin
      cnt_q     <= cnt_d;
      armed_q   <= armed_d;
      verdict_q <= verdict_d;
    end
  end

  assign verdict_o = verdict_q;
endmodule

// File: rtl/tpd_follower.sv
module tpd_follower
  import tpd_pkg::*;
#(
  parameter int unsigned RUN_LEN = 8,
  localparam int unsigned RUN_W  = $clog2(RUN_LEN + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  tpd_verdict_t verdict_i,
  output logic         present_o
);
  logic             present_q, present_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             run_en;

  assign run_en = verdict_i.valid;

  always_comb begin
    present_d = present_q;
    run_d     = run_q;
    if (run_en) begin
      if (verdict_i.good != present_q) begin
        if (run_q == RUN_W'(RUN_LEN - 1)) begin
          present_d = verdict_i.good;
          run_d     = '0;
        end else begin
          run_d = run_q + RUN_W'(1);
        end
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      present_q <= 1'b0;
      run_q     <= '0;
    end else if (run_en) begin
      present_q <= present_d;
      run_q     <= run_d;
    end
  end

  assign present_o = present_q;
endmodule

// File: rtl/tpd_tone_detector.sv
module tpd_tone_detector
  import tpd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ACC16_LO    = 218,
  parameter int unsigned ACC16_HI    = 230,
  parameter int unsigned TMO16       = 268,
  parameter int unsigned ACC12_LO    = 290,
  parameter int unsigned ACC12_HI    = 306,
  parameter int unsigned TMO12       = 358,
  parameter int unsigned RUN_LEN     = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_sel_i,
  input  logic tone_i,
  output logic follower_no,
  output logic verdict_valid_o,
  output logic verdict_good_o
);
  logic         rst_n;
  logic         rise;
  tpd_sys_e     sys_q, sys_d;
  tpd_verdict_t verdict;
  logic         present;

  tpd_reset_sync #(.STAGES(2)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_n)
  );

  tpd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .async_i(tone_i),
    .rise_o (rise)
  );

  assign sys_d = tpd_sys_e'(sys_sel_i);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) sys_q <= SYS_12K;
    else        sys_q <= sys_d;
  end

  tpd_period_meter #(
    .ACC16_LO(ACC16_LO), .ACC16_HI(ACC16_HI), .TMO16(TMO16),
    .ACC12_LO(ACC12_LO), .ACC12_HI(ACC12_HI), .TMO12(TMO12)
  ) u_meter (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .sys_i    (sys_q),
    .rise_i   (rise),
    .verdict_o(verdict)
  );

  tpd_follower #(.RUN_LEN(RUN_LEN)) u_follow (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .verdict_i(verdict),
    .present_o(present)
  );

  assign follower_no     = ~present;
  assign verdict_valid_o = verdict.valid;
  assign verdict_good_o  = verdict.good;
endmodule

// File: rtl/tpd_tone_detector_chk.sv
module tpd_tone_detector_chk #(
  parameter int unsigned GAP_MAX = 720
) (
  input logic clk_i,
  input logic rst_ni,
  input logic follower_no,
  input logic verdict_valid_o,
  input logic verdict_good_o
);
  logic [10:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              gap_q <= '0;
    else if (verdict_valid_o) gap_q <= '0;
    else if (gap_q != '1)     gap_q <= gap_q + 11'd1;
  end

  a_r1_good_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_good_o |-> verdict_valid_o);

  a_r4_strobe_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_valid_o |=> !verdict_valid_o);

  a_r5_gap_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q <= 11'(GAP_MAX));

  a_r6_fall_after_good: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(follower_no) |-> $past(verdict_valid_o && verdict_good_o));

  a_r6_rise_after_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(follower_no) |-> $past(verdict_valid_o && !verdict_good_o));
endmodule

bind tpd_tone_detector tpd_tone_detector_chk #(.GAP_MAX(2 * 358 + 4)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .follower_no    (follower_no),
  .verdict_valid_o(verdict_valid_o),
  .verdict_good_o (verdict_good_o)
);

// File: tb/tpd_tone_detector_tb.sv
module tpd_tone_detector_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_sel = 1'b0;
  logic tone = 1'b0;
  logic follower_n, vvalid, vgood;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int dec_total = 0;
  int good_total = 0;
  int last_good = 0;
  int fall_cyc = -1;
  int rise_cyc = -1;

  always #2.5 clk = ~clk;

  tpd_tone_detector dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sys_sel_i(sys_sel), .tone_i(tone),
    .follower_no(follower_n), .verdict_valid_o(vvalid), .verdict_good_o(vgood)
  );

  logic prev_f = 1'b1;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (vvalid) begin
      dec_total  <= dec_total + 1;
      good_total <= good_total + (vgood ? 1 : 0);
      last_good  <= vgood ? 1 : 0;
    end
    if (prev_f && !follower_n) fall_cyc <= cyc;
    if (!prev_f && follower_n) rise_cyc <= cyc;
    prev_f <= follower_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic burst(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      tone = 1'b1;
      repeat (p / 2) @(negedge clk);
      tone = 1'b0;
      repeat (p - p / 2) @(negedge clk);
    end
  endtask

  task automatic idle();
    tone = 1'b0;
    repeat (800) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    check(follower_n == 1'b1, "R1 follower in reset", follower_n, 1);
    check(vvalid == 1'b0, "R1 strobe in reset", vvalid, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(follower_n == 1'b1, "R1 follower after reset", follower_n, 1);
  endtask

  task automatic t_band(input int p, input int exp, input string req);
    idle();
    burst(p, 3);
    check(last_good == exp, req, last_good, exp);
  endtask

  task automatic t_count_r4();
    int d0, g0;
    idle();
    d0 = dec_total; g0 = good_total;
    burst(224, 5);
    check(dec_total - d0 == 4, "R4 verdicts per edges", dec_total - d0, 4);
    check(good_total - g0 == 4, "R4 good verdicts", good_total - g0, 4);
  endtask

  task automatic t_latency_r9();
    idle();
    burst(224, 1);
    tone = 1'b1;
    @(negedge clk); @(negedge clk);
    check(vvalid == 1'b0, "R9 strobe early", vvalid, 0);
    @(negedge clk);
    check(vvalid == 1'b1, "R9 strobe at third", vvalid, 1);
    repeat (100) @(negedge clk);
    tone = 1'b0;
  endtask

  task automatic t_timeout_r5(input int exp);
    int gap;
    bit bad_seen;
    idle();
    while (!vvalid) @(negedge clk);
    gap = 0;
    @(negedge clk);
    gap = 1;
    while (!vvalid && gap < 2000) begin @(negedge clk); gap++; end
    bad_seen = !vgood;
    check(gap == exp, "R5 timeout spacing", gap, exp);
    check(bad_seen, "R5 timeout verdict bad", vgood, 0);
  endtask

  task automatic t_follow_r6_r7_r8();
    int start;
    idle();
    start = cyc;
    burst(224, 8);
    check(follower_n == 1'b1, "R6 no response after 7 good", follower_n, 1);
    burst(224, 1);
    check(follower_n == 1'b0, "R6 response after 8 good", follower_n, 0);
    check(fall_cyc - start <= 14318, "R8 response time", fall_cyc - start, 14318);
    burst(224, 3);
    burst(250, 1);
    burst(224, 3);
    check(follower_n == 1'b0, "R7 single glitch ignored", follower_n, 0);
    burst(240, 7);
    burst(224, 2);
    check(follower_n == 1'b0, "R7 seven bad ignored", follower_n, 0);
    burst(240, 8);
    check(follower_n == 1'b0, "R6 still low after 7 bad", follower_n, 0);
    burst(240, 1);
    check(follower_n == 1'b1, "R6 de-response after 8 bad", follower_n, 1);
    burst(224, 10);
    check(follower_n == 1'b0, "R6 response again", follower_n, 0);
    start = cyc;
    tone = 1'b0;
    while (follower_n == 1'b0 && cyc - start < 20000) @(negedge clk);
    check(follower_n == 1'b1 && cyc - start <= 14318, "R8 de-response time", cyc - start, 14318);
    check(cyc - start >= 7 * 268, "R7 de-response not early", cyc - start, 7 * 268);
  endtask

  task automatic t_wrong_system();
    idle();
    burst(224, 12);
    check(follower_n == 1'b1, "R3 16k tone in 12k mode", follower_n, 1);
  endtask

  initial begin
    t_reset();
    sys_sel = 1'b0;
    t_band(218, 1, "R2 lower accept edge");
    t_band(224, 1, "R2 nominal");
    t_band(230, 1, "R2 upper accept edge");
    t_band(217, 0, "R2 below lower edge");
    t_band(231, 0, "R2 above upper edge");
    t_band(214, 0, "R2 beyond +4%");
    t_count_r4();
    t_latency_r9();
    t_timeout_r5(268);
    t_follow_r6_r7_r8();
    sys_sel = 1'b1;
    t_band(290, 1, "R3 lower accept edge");
    t_band(298, 1, "R3 nominal");
    t_band(306, 1, "R3 upper accept edge");
    t_band(289, 0, "R3 below lower edge");
    t_band(307, 0, "R3 above upper edge");
    t_timeout_r5(358);
    t_wrong_system();
    finish_run();
  end

  initial begin
    while (cyc < 150000) @(negedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    finish_run();
  end
endmodule